// File: doc/BRIEF.md
# Configurable GPIO Pin Controller

This block controls a single general-purpose I/O pin through a small control register. In input mode the pad is brought through a two-flop synchronizer. It then passes an optional polarity inversion, an optional noise filter that spans milliseconds, and an optional sticky capture flag, and the result reaches internal logic on `coreIn`. In output mode the pad is driven low, driven high, or driven from one of two toggling clocks that other logic supplies. A third mode gives the pad to an alternate function, which then drives the output value and the output enable itself.

Software programs the pin with a write strobe and a 6-bit data word. It reads the configuration back on a combinational read port, and the same port reports the live, synchronized pad level.

The filter counts ticks from a prescaler. At default parameters, with a 50 MHz clock, a tick is about 1 ms and the filter needs 14 consecutive stable ticks. A level change therefore reaches the output between 13 and 14 ms after the pad settles, which is inside a 12 to 16 ms window.

Top module: `gpio_pin_top`

## Requirements
- R1: After reset the pin is in GPIO input mode, active low, unlatched, with the filter off. `cfgRdata[4:0]` reads 0, `padOe` and `padOut` are 0, and the synchronizer and filter start at logic 1, so an idle-high pad gives `coreIn` = 0.
- R2: A write with `cfgWe` stores `cfgWdata[1:0]` as the sub-field, `cfgWdata[3:2]` as the mode and `cfgWdata[4]` as the filter enable. `cfgRdata[4:0]` returns these bits at the same positions from the next cycle on.
- R3: Mode 00 is GPIO input with `padOe` = 0. Mode 01 is GPIO output with `padOe` = 1. Mode 10 or 11 is alternate, in which `padOut` = `altOut` and `padOe` = `altOe`. `coreIn` is 0 in every mode other than input.
- R4: In output mode a sub-field value of 0 drives `padOut` low and 1 drives it high. Value 2 drives `padOut` from `outClk0` and value 3 from `outClk1`, both combinationally.
- R5: In input mode sub-field bit 0 selects polarity. With 0 the pad is inverted (active low); with 1 it is passed through. With the filter off, `coreIn` follows a pad change two clock edges later.
- R6: In input mode sub-field bit 1 = 1 makes `coreIn` show a sticky flag. The flag sets on the active level of the conditioned input and stays set after the pad returns to inactive.
- R7: A write with `cfgWdata[5]` = 1 clears the sticky flag. If the active level is present in the same cycle the flag stays set. Bit 5 is not stored.
- R8: With the filter on, a new pad level reaches the input path only after `STABLE_TICKS` consecutive prescaler ticks with no change. Any change, including a one-cycle glitch, restarts the count.
- R9: `cfgRdata[5]` reports the synchronized pad level without inversion, in every mode and at every polarity.
- R10: In alternate mode the sub-field has no effect on `padOut` or `padOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 6 | Write data: [1:0] sub-field, [3:2] mode, [4] filter enable, [5] clear sticky flag |
| cfgRdata | output | 6 | Read data: [4:0] stored configuration, [5] live synchronized pad level |
| padIn | input | 1 | Level from the pad |
| padOut | output | 1 | Value driven to the pad |
| padOe | output | 1 | Pad output enable |
| outClk0 | input | 1 | First external toggling clock for output mode |
| outClk1 | input | 1 | Second external toggling clock for output mode |
| altOut | input | 1 | Output value from the alternate function |
| altOe | input | 1 | Output enable from the alternate function |
| coreIn | output | 1 | Conditioned input delivered to internal logic |
| altIn | output | 1 | Synchronized pad level for the alternate function |

## Verification
The hardest case to reach from the ports is a glitch that arrives partway through a filter window. The filter count then has to restart, not carry on, and a window that simply runs from the first edge would still pass every steady-level test. The bench uses a short prescaler. It holds a new level for about half the window, pulses the pad back for one cycle, and samples `coreIn` at a point that would already have updated had the count not restarted. It then samples again after a full window has passed. The tie between a clear and a set is reached by writing the clear bit while the pad is held at its active level.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  // Strobes passed from the control register to the datapath
  typedef struct packed {
    logic       isInput;
    logic       isOutput;
    logic       isAlt;
    logic       invert;
    logic       useLatch;
    logic       filtEn;
    logic       latchClr;
    logic [1:0] outSel;
  } pinStrobe_t;

  typedef enum logic [1:0] {
    OSEL_LOW  = 2'd0,
    OSEL_HIGH = 2'd1,
    OSEL_CLK0 = 2'd2,
    OSEL_CLK1 = 2'd3
  } outSel_e;

  localparam int CFG_W = 6;

endpackage

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             padLive,
  output logic [CFG_W-1:0] cfgRdata,
  output pinStrobe_t       strb
);

  logic [1:0] subQ;
  logic [1:0] modeQ;
  logic       filtEnQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subQ    <= 2'b00;
      modeQ   <= 2'b00;
      filtEnQ <= 1'b0;
    end else if (cfgWe) begin
      subQ    <= cfgWdata[1:0];
      modeQ   <= cfgWdata[3:2];
      filtEnQ <= cfgWdata[4];
    end
  end

  always_comb begin
    strb.isInput  = (modeQ == 2'b00);
    strb.isOutput = (modeQ == 2'b01);
    strb.isAlt    = modeQ[1];
    strb.invert   = ~subQ[0];
    strb.useLatch = subQ[1];
    strb.filtEn   = filtEnQ;
    strb.latchClr = cfgWe & cfgWdata[5];
    strb.outSel   = subQ;
  end

  assign cfgRdata = {padLive, filtEnQ, modeQ, subQ};

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWe |=> (cfgRdata[4:0] == $past(cfgWdata[4:0])));

  // R3
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({strb.isInput, strb.isOutput, strb.isAlt}));

endmodule

// File: rtl/gpio_pin_dp.sv
module gpio_pin_dp
  import gpio_pin_pkg::*;
#(
  parameter int TICK_CYCLES  = 50000,
  parameter int STABLE_TICKS = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pinStrobe_t strb,
  input  logic       padIn,
  input  logic       outClk0,
  input  logic       outClk1,
  input  logic       altOut,
  input  logic       altOe,
  output logic       padOut,
  output logic       padOe,
  output logic       coreIn,
  output logic       padLive
);

  localparam int PRE_W = (TICK_CYCLES  > 1) ? $clog2(TICK_CYCLES)  : 1;
  localparam int STB_W = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;

  // Two-flop synchronizer, idle high
  logic syncA, padSync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA   <= 1'b1;
      padSync <= 1'b1;
    end else begin
      syncA   <= padIn;
      padSync <= syncA;
    end
  end
  assign padLive = padSync;

  // Prescaler tick
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  assign tick = (preCnt == PRE_W'(TICK_CYCLES - 1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // Stability filter: restart on any change of the sampled level
  logic             prevSample, filtQ;
  logic [STB_W-1:0] stableCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSample <= 1'b1;
      filtQ      <= 1'b1;
      stableCnt  <= '0;
    end else begin
      prevSample <= padSync;
      if ((padSync != prevSample) || (padSync == filtQ)) begin
        stableCnt <= '0;
      end else if (tick) begin
        if (stableCnt == STB_W'(STABLE_TICKS - 1)) begin
          filtQ     <= padSync;
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end
  end

  // Polarity and sticky flag
  logic srcBit, condActive, latchQ;
  assign srcBit     = strb.filtEn ? filtQ : padSync;
  assign condActive = srcBit ^ strb.invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            latchQ <= 1'b0;
    else if (strb.isInput && condActive)   latchQ <= 1'b1;
    else if (strb.latchClr)                latchQ <= 1'b0;
  end

  assign coreIn = strb.isInput & (strb.useLatch ? latchQ : condActive);

  // Output drive
  always_comb begin
    padOut = 1'b0;
    padOe  = 1'b0;
    if (strb.isAlt) begin
      padOut = altOut;
      padOe  = altOe;
    end else if (strb.isOutput) begin
      padOe = 1'b1;
      unique case (outSel_e'(strb.outSel))
        OSEL_LOW:  padOut = 1'b0;
        OSEL_HIGH: padOut = 1'b1;
        OSEL_CLK0: padOut = outClk0;
        OSEL_CLK1: padOut = outClk1;
      endcase
    end
  end

  // R3
  in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.isInput |-> !padOe);

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latchQ && !strb.latchClr) |=> latchQ);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latchClr && strb.isInput && condActive) |=> latchQ);

  // R8
  filt_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filtQ != $past(filtQ)) |-> (filtQ == $past(padSync) && $past(tick)));

endmodule

// File: rtl/gpio_pin_top.sv
module gpio_pin_top
  import gpio_pin_pkg::*;
#(
  parameter int TICK_CYCLES  = 50000,
  parameter int STABLE_TICKS = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWe,
  input  logic [5:0] cfgWdata,
  output logic [5:0] cfgRdata,
  input  logic       padIn,
  output logic       padOut,
  output logic       padOe,
  input  logic       outClk0,
  input  logic       outClk1,
  input  logic       altOut,
  input  logic       altOe,
  output logic       coreIn,
  output logic       altIn
);

  pinStrobe_t strb;
  logic       padLive;

  gpio_pin_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .padLive  (padLive),
    .cfgRdata (cfgRdata),
    .strb     (strb)
  );

  gpio_pin_dp #(
    .TICK_CYCLES  (TICK_CYCLES),
    .STABLE_TICKS (STABLE_TICKS)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .padIn   (padIn),
    .outClk0 (outClk0),
    .outClk1 (outClk1),
    .altOut  (altOut),
    .altOe   (altOe),
    .padOut  (padOut),
    .padOe   (padOe),
    .coreIn  (coreIn),
    .padLive (padLive)
  );

  assign altIn = padLive;

endmodule

// File: tb/sim_gpio_pin_top.sv
`timescale 1ns/1ps
module sim_gpio_pin_top;

  localparam int TICK   = 8;
  localparam int STABLE = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWe = 1'b0;
  logic [5:0] cfgWdata = '0;
  logic [5:0] cfgRdata;
  logic       padIn = 1'b1;
  logic       padOut, padOe, coreIn, altIn;
  logic       outClk0 = 1'b0, outClk1 = 1'b0, altOut = 1'b0, altOe = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_pin_top #(.TICK_CYCLES(TICK), .STABLE_TICKS(STABLE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .outClk0(outClk0), .outClk1(outClk1), .altOut(altOut), .altOe(altOe),
    .coreIn(coreIn), .altIn(altIn)
  );

  // {mode, sub, pad, clk0, clk1, altOut, altOe, expOut, expOe, expCore}
  localparam logic [11:0] VEC [14] = '{
    {2'b00, 2'b00, 1'b1, 4'b0000, 3'b000},  // R5 active low, pad high
    {2'b00, 2'b00, 1'b0, 4'b0000, 3'b001},  // R5 active low, pad low
    {2'b00, 2'b01, 1'b1, 4'b0000, 3'b001},  // R5 active high, pad high
    {2'b00, 2'b01, 1'b0, 4'b0000, 3'b000},  // R5 active high, pad low
    {2'b01, 2'b00, 1'b1, 4'b1100, 3'b010},  // R4 forced low
    {2'b01, 2'b01, 1'b0, 4'b0000, 3'b110},  // R4 forced high
    {2'b01, 2'b10, 1'b1, 4'b1000, 3'b110},  // R4 clock 0 high
    {2'b01, 2'b10, 1'b0, 4'b0100, 3'b010},  // R4 clock 0 low
    {2'b01, 2'b11, 1'b1, 4'b0100, 3'b110},  // R4 clock 1 high
    {2'b01, 2'b11, 1'b0, 4'b1000, 3'b010},  // R4 clock 1 low
    {2'b10, 2'b00, 1'b1, 4'b0011, 3'b110},  // R3 alternate
    {2'b11, 2'b01, 1'b0, 4'b0000, 3'b000},  // R3 alternate, released
    {2'b10, 2'b11, 1'b1, 4'b0011, 3'b110},  // R10 sub ignored
    {2'b11, 2'b10, 1'b0, 4'b0001, 3'b010}   // R10 sub ignored
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk);
    cfgWe    = 1'b1;
    cfgWdata = d;
    @(negedge clk);
    cfgWe    = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", {2'b0, cfgRdata}, 8'h20);
    chk("R1 coreIn/oe/out", {5'b0, coreIn, padOe, padOut}, 8'h0);

    // R2 field positions
    wr(6'b011110);
    chk("R2 readback", {3'b0, cfgRdata[4:0]}, 8'h1e);

    // Vector table: R3 R4 R5 R9 R10
    for (int i = 0; i < 14; i++) begin
      wr({2'b00, VEC[i][11:8]});
      @(negedge clk);
      padIn   = VEC[i][7];
      outClk0 = VEC[i][6];
      outClk1 = VEC[i][5];
      altOut  = VEC[i][4];
      altOe   = VEC[i][3];
      waitc(4);
      chk($sformatf("R3/R4/R5/R10 vec %0d", i),
          {5'b0, padOut, padOe, coreIn}, {5'b0, VEC[i][2:0]});
      chk($sformatf("R9 live vec %0d", i), {7'b0, cfgRdata[5]}, {7'b0, VEC[i][7]});
    end

    // R6 sticky flag, active high, latched
    padIn = 1'b0;
    waitc(3);
    wr(6'b100011);
    waitc(2);
    chk("R6 cleared start", {7'b0, coreIn}, 8'h0);
    @(negedge clk); padIn = 1'b1;
    @(negedge clk); padIn = 1'b0;
    waitc(5);
    chk("R6 flag held", {7'b0, coreIn}, 8'h1);
    // R7 clear
    wr(6'b100011);
    waitc(2);
    chk("R7 clear", {7'b0, coreIn}, 8'h0);
    // R7 set wins over clear
    padIn = 1'b1;
    waitc(4);
    wr(6'b100011);
    waitc(2);
    chk("R7 set wins", {7'b0, coreIn}, 8'h1);
    padIn = 1'b0;
    waitc(4);
    wr(6'b100011);
    waitc(2);
    chk("R7 clear after", {7'b0, coreIn}, 8'h0);

    // R8 filter, active high, unlatched
    wr(6'b010001);
    padIn = 1'b0;
    waitc((STABLE + 6) * TICK);
    chk("R8 settled low", {7'b0, coreIn}, 8'h0);
    padIn = 1'b1;
    waitc(10 * TICK);
    chk("R8 before window", {7'b0, coreIn}, 8'h0);
    waitc(8 * TICK);
    chk("R8 after window", {7'b0, coreIn}, 8'h1);
    padIn = 1'b0;
    waitc(6 * TICK);
    padIn = 1'b1;
    @(negedge clk);
    padIn = 1'b0;
    waitc(10 * TICK);
    chk("R8 glitch restarts count", {7'b0, coreIn}, 8'h1);
    waitc(8 * TICK);
    chk("R8 low after full window", {7'b0, coreIn}, 8'h0);
    chk("R9 live while filtered", {7'b0, cfgRdata[5]}, 8'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule